// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It works in two levels. The first level keeps a shift register of recent branch outcomes. The second level is a table of two-bit saturating counters, and the history pattern picks the counter to read. An elaboration parameter selects one of three arrangements:

- **Shared history.** One history register serves every branch.
- **Per-branch history.** Low address bits pick one history register out of a small table.
- **Hashed.** The shared history is XORed with address bits, which spreads unrelated branches across the counter table.

The fetch side supplies a branch address. The block answers in the same cycle with a direction bit and the history value it used. The back end later reports the resolved address and outcome, and hands back that same history value. The counter is trained at the index the prediction used. History is advanced only at resolution, never speculatively.

Top module: `bp2_predictor`

## Requirements
- R1: For one cycle after reset, and until the first update: every history register reads zero, and every counter holds weakly taken (2'b10), so `pred_taken` is 1 for every address.
- R2: `pred_taken` is the most significant bit of the counter selected by the current inputs and state, and it is valid in the same cycle as `pred_addr` (combinational read).
- R3: Each counter saturates. A taken update adds one, up to 2'b11. A not-taken update subtracts one, down to 2'b00.
- R4: An update trains the counter whose index is formed from `upd_hist` together with `upd_addr`. The current history does not enter into this index.
- R5: On an update, the affected history register becomes `{old[HIST_W-2:0], upd_taken}`, where 1 means taken.
- R6: In shared-history mode (ORG_GLOBAL), every update shifts the single history register, whatever its address. The counter index equals that history.
- R7: In per-branch mode (ORG_PERADDR), bits `addr[7:2]` select one of 64 history registers, and an update shifts only the selected register. The counter index equals that register.
- R8: In hashed mode (ORG_XOR), the counter index is `history ^ addr[11:2]`, for both prediction and update.
- R9: A prediction made in the same cycle as an update reflects the state before that update. The update becomes visible from the next cycle.
- R10: Without `upd_valid`, no history register and no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_addr | input | ADDR_W | Address of the branch being fetched |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History value returned from prediction time |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A prediction and a resolution can occur in the same cycle, often for the same branch or for branches that alias onto the same counter. The bench provokes this by driving `pred_addr` equal to `upd_addr` in a large share of random cycles. It also draws addresses from a small pool so that per-branch slots and hashed indices collide. In every cycle, before the clock edge, the outputs must match a reference model that still holds the state from before the update. After the edge, the model applies the update, and the following cycle shows the result. Stale `upd_hist` values are mixed in so that training at the prediction-time index is judged separately from training at the current history.

// File: rtl/bp2_pkg.sv
package bp2_pkg;

    // Organisation of the first level and of the index hash
    typedef enum logic [1:0] {
        ORG_GLOBAL  = 2'd0,
        ORG_PERADDR = 2'd1,
        ORG_XOR     = 2'd2
    } org_e;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b10;
    localparam ctr_t CTR_MAX   = 2'b11;
    localparam ctr_t CTR_MIN   = 2'b00;

    // Resolved branch reported by the back end
    typedef struct packed {
        logic valid;
        logic taken;
    } resolve_t;

    // Saturating move toward the outcome
    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t n;
        if (taken) n = (c == CTR_MAX) ? c : c + 2'd1;
        else       n = (c == CTR_MIN) ? c : c - 2'd1;
        return n;
    endfunction

    function automatic logic ctr_dir(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp2_history.sv
module bp2_history
    import bp2_pkg::*;
#(
    parameter org_e ORG        = ORG_XOR,
    parameter int   HIST_W     = 10,
    parameter int   PA_ENTRIES = 64,
    parameter int   ADDR_W     = 32,
    parameter int   ADDR_LSB   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HIST_W-1:0] rd_hist,
    input  resolve_t          res,
    input  logic [ADDR_W-1:0] res_addr
);
    localparam int SEL_W = (PA_ENTRIES > 1) ? $clog2(PA_ENTRIES) : 1;

    generate
        if (ORG == ORG_PERADDR) begin : g_table
            logic [HIST_W-1:0] tbl [PA_ENTRIES];
            logic [SEL_W-1:0]  rd_sel;
            logic [SEL_W-1:0]  wr_sel;

            assign rd_sel  = rd_addr[ADDR_LSB +: SEL_W];
            assign wr_sel  = res_addr[ADDR_LSB +: SEL_W];
            assign rd_hist = tbl[rd_sel];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < PA_ENTRIES; i++) tbl[i] <= '0;
                end else if (res.valid) begin
                    tbl[wr_sel] <= {tbl[wr_sel][HIST_W-2:0], res.taken};
                end
            end
        end else begin : g_shared
            logic [HIST_W-1:0] ghr;

            assign rd_hist = ghr;

            always_ff @(posedge clk) begin
                if (rst)            ghr <= '0;
                else if (res.valid) ghr <= {ghr[HIST_W-2:0], res.taken};
            end
        end
    endgenerate
endmodule

// File: rtl/bp2_index.sv
module bp2_index
    import bp2_pkg::*;
#(
    parameter org_e ORG      = ORG_XOR,
    parameter int   HIST_W   = 10,
    parameter int   ADDR_W   = 32,
    parameter int   ADDR_LSB = 2
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [ADDR_W-1:0] addr,
    output logic [HIST_W-1:0] idx
);
    generate
        if (ORG == ORG_XOR) begin : g_hash
            assign idx = hist ^ addr[ADDR_LSB +: HIST_W];
        end else begin : g_plain
            assign idx = hist;
        end
    endgenerate
endmodule

// File: rtl/bp2_pht.sv
module bp2_pht
    import bp2_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  resolve_t         res,
    input  logic [IDX_W-1:0] wr_idx
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t cnt [DEPTH];

    assign rd_ctr = cnt[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cnt[i] <= CTR_RESET;
        end else if (res.valid) begin
            cnt[wr_idx] <= ctr_step(cnt[wr_idx], res.taken);
        end
    end
endmodule

// File: rtl/bp2_predictor.sv
module bp2_predictor
    import bp2_pkg::*;
#(
    parameter org_e ORG        = ORG_XOR,
    parameter int   HIST_W     = 10,
    parameter int   PA_ENTRIES = 64,
    parameter int   ADDR_W     = 32,
    parameter int   ADDR_LSB   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);
    resolve_t          res;
    logic [HIST_W-1:0] rd_idx;
    logic [HIST_W-1:0] wr_idx;
    ctr_t              rd_ctr;

    assign res.valid = upd_valid;
    assign res.taken = upd_taken;

    bp2_history #(
        .ORG(ORG), .HIST_W(HIST_W), .PA_ENTRIES(PA_ENTRIES),
        .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)
    ) u_hist (
        .clk(clk), .rst(rst),
        .rd_addr(pred_addr), .rd_hist(pred_hist),
        .res(res), .res_addr(upd_addr)
    );

    bp2_index #(
        .ORG(ORG), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)
    ) u_idx_rd (
        .hist(pred_hist), .addr(pred_addr), .idx(rd_idx)
    );

    bp2_index #(
        .ORG(ORG), .HIST_W(HIST_W), .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)
    ) u_idx_wr (
        .hist(upd_hist), .addr(upd_addr), .idx(wr_idx)
    );

    bp2_pht #(.IDX_W(HIST_W)) u_pht (
        .clk(clk), .rst(rst),
        .rd_idx(rd_idx), .rd_ctr(rd_ctr),
        .res(res), .wr_idx(wr_idx)
    );

    assign pred_taken = ctr_dir(rd_ctr);
endmodule

// File: rtl/bp2_checker.sv
module bp2_checker
    import bp2_pkg::*;
#(
    parameter org_e ORG        = ORG_XOR,
    parameter int   HIST_W     = 10,
    parameter int   PA_ENTRIES = 64,
    parameter int   ADDR_W     = 32,
    parameter int   ADDR_LSB   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pred_addr,
    input logic              pred_taken,
    input logic [HIST_W-1:0] pred_hist,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_addr,
    input logic              upd_taken
);
    localparam int SEL_W = (PA_ENTRIES > 1) ? $clog2(PA_ENTRIES) : 1;

    // R1: the first cycle after reset predicts taken from a cleared history
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (pred_taken && pred_hist == '0));

    // R2: the direction bit never goes unknown outside reset
    a_r2_known: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(pred_taken));

    generate
        if (ORG == ORG_PERADDR) begin : g_pa
            // R7: an update to another slot leaves this slot's history alone
            a_r7_slot_isolated: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $stable(pred_addr) &&
                 (!$past(upd_valid) ||
                  $past(upd_addr[ADDR_LSB +: SEL_W]) != pred_addr[ADDR_LSB +: SEL_W]))
                |-> $stable(pred_hist));
        end else begin : g_shared
            // R10: history holds without an update
            a_r10_hist_hold: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(upd_valid)) |-> $stable(pred_hist));

            // R5 / R6: any update shifts its outcome into the shared history
            a_r5_shift_in: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(upd_valid)) |->
                (pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}));
        end
    endgenerate
endmodule

bind bp2_predictor bp2_checker #(
    .ORG(ORG), .HIST_W(HIST_W), .PA_ENTRIES(PA_ENTRIES),
    .ADDR_W(ADDR_W), .ADDR_LSB(ADDR_LSB)
) u_chk (
    .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_taken(upd_taken)
);

// File: tb/tb_bp2_predictor.sv
`timescale 1ns/1ps
module tb_bp2_predictor;
    import bp2_pkg::*;

    localparam int HW  = 10;
    localparam int PAE = 64;
    localparam int AW  = 32;
    localparam int NT  = 1 << HW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic [AW-1:0] pred_addr = '0;
    logic [AW-1:0] upd_addr  = '0;
    logic          upd_valid = 1'b0;
    logic          upd_taken = 1'b0;
    logic [HW-1:0] uh0 = '0, uh1 = '0, uh2 = '0;
    logic          pt0, pt1, pt2;
    logic [HW-1:0] ph0, ph1, ph2;

    // o = 0 shared, 1 per-branch, 2 hashed
    bp2_predictor #(.ORG(ORG_GLOBAL)) dut_ga (
        .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pt0), .pred_hist(ph0),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_hist(uh0), .upd_taken(upd_taken));
    bp2_predictor #(.ORG(ORG_PERADDR)) dut_pa (
        .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pt1), .pred_hist(ph1),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_hist(uh1), .upd_taken(upd_taken));
    bp2_predictor #(.ORG(ORG_XOR)) dut (
        .clk(clk), .rst(rst), .pred_addr(pred_addr), .pred_taken(pt2), .pred_hist(ph2),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_hist(uh2), .upd_taken(upd_taken));

    // Behavioural reference
    int            m_pht [3][NT];
    logic [HW-1:0] m_g   [3];
    logic [HW-1:0] m_pa  [PAE];
    logic [HW-1:0] snap  [3];

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    function automatic logic [HW-1:0] m_hist(int o, logic [AW-1:0] a);
        return (o == 1) ? m_pa[a[7:2]] : m_g[o];
    endfunction

    function automatic int m_idx(int o, logic [HW-1:0] h, logic [AW-1:0] a);
        return (o == 2) ? int'(h ^ a[11:2]) : int'(h);
    endfunction

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int o = 0; o < 3; o++) begin
            m_g[o] = '0;
            snap[o] = '0;
            for (int i = 0; i < NT; i++) m_pht[o][i] = 2;
        end
        for (int i = 0; i < PAE; i++) m_pa[i] = '0;
    endtask

    // One cycle: drive at negedge, compare before the edge, then advance the model
    task automatic cyc(logic [AW-1:0] pa, logic uv, logic [AW-1:0] ua, logic ut, bit stale);
        logic [HW-1:0] h [3];
        logic          gp [3];
        logic [HW-1:0] gh [3];
        @(negedge clk);
        pred_addr = pa; upd_valid = uv; upd_addr = ua; upd_taken = ut;
        for (int o = 0; o < 3; o++) h[o] = stale ? snap[o] : m_hist(o, ua);
        uh0 = h[0]; uh1 = h[1]; uh2 = h[2];
        #1;
        gp[0] = pt0; gp[1] = pt1; gp[2] = pt2;
        gh[0] = ph0; gh[1] = ph1; gh[2] = ph2;
        for (int o = 0; o < 3; o++) begin
            int ep;
            int eh;
            ep = (m_pht[o][m_idx(o, m_hist(o, pa), pa)] >= 2) ? 1 : 0;
            eh = int'(m_hist(o, pa));
            chk(gp[o] === ep[0], $sformatf("org%0d pred_taken", o), int'(gp[o]), ep);
            chk(gh[o] === eh[HW-1:0], $sformatf("org%0d pred_hist", o), int'(gh[o]), eh);
        end
        @(posedge clk);
        if (uv) begin
            for (int o = 0; o < 3; o++) begin
                int k;
                k = m_idx(o, h[o], ua);
                if (ut) m_pht[o][k] = (m_pht[o][k] == 3) ? 3 : m_pht[o][k] + 1;
                else    m_pht[o][k] = (m_pht[o][k] == 0) ? 0 : m_pht[o][k] - 1;
            end
            m_g[0] = {m_g[0][HW-2:0], ut};
            m_g[2] = {m_g[2][HW-2:0], ut};
            m_pa[ua[7:2]] = {m_pa[ua[7:2]][HW-2:0], ut};
        end
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        return AW'({$urandom_range(0, 255), 2'b00});
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, various addresses, no updates (also R10)
        cur_tag = "R1";
        for (int i = 0; i < 6; i++) cyc(AW'(i * 52), 1'b0, '0, 1'b0, 1'b0);

        // R3: saturate down then up on one counter, fixed update history of zero
        cur_tag = "R3";
        for (int i = 0; i < 4; i++) cyc(32'h40, 1'b1, 32'h40, 1'b0, 1'b1);
        cyc(32'h40, 1'b0, '0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) cyc(32'h40, 1'b1, 32'h40, 1'b1, 1'b1);
        cyc(32'h40, 1'b0, '0, 1'b0, 1'b0);

        // R6 / R7 / R5: alternating addresses in different slots, taken pattern
        cur_tag = "R7";
        for (int i = 0; i < 24; i++)
            cyc((i % 2) ? 32'h104 : 32'h208, 1'b1, (i % 2) ? 32'h208 : 32'h104,
                1'(i % 3 != 0), 1'b0);

        // R8: hashed indices with high address bits set
        cur_tag = "R8";
        for (int i = 0; i < 40; i++)
            cyc(32'hFFC - AW'(i * 4), 1'b1, 32'hFFC - AW'(i * 8), 1'(i % 2), 1'b0);

        // R4: train with a stale history snapshot while current history moves on
        cur_tag = "R4";
        for (int o = 0; o < 3; o++) snap[o] = m_hist(o, 32'h3C);
        for (int i = 0; i < 8; i++) cyc(32'h3C, 1'b1, 32'h3C, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) cyc(32'h3C, 1'b1, 32'h3C, 1'b0, 1'b1);

        // R9 / R2 / R10: random traffic with frequent same-cycle collisions
        cur_tag = "R9";
        for (int i = 0; i < 6000; i++) begin
            logic [AW-1:0] ua;
            logic [AW-1:0] pa;
            int            r;
            ua = rnd_addr();
            r  = $urandom_range(0, 99);
            pa = (r < 40) ? ua : rnd_addr();
            if ($urandom_range(0, 19) == 0)
                for (int o = 0; o < 3; o++) snap[o] = m_hist(o, ua);
            cyc(pa, 1'($urandom_range(0, 99) < 70), ua, 1'($urandom_range(0, 1)),
                $urandom_range(0, 4) == 0);
        end

        // R1: reset again in mid-run returns everything to its initial state
        cur_tag = "R1";
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) cyc(rnd_addr(), 1'b0, '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule